// File: doc/BRIEF.md
# Path Trace Message Monitor

This block watches the path trace byte carried once per frame and decides whether the repeating message it builds up matches a message that has been programmed in advance. A strobe marks each frame that carries a new byte. The block locks onto the start of the message itself and then compares every byte against a 64-entry expected-message register file. Software fills that file through a plain address, data and write-enable port.

Two message formats are handled. In the long format the message is 64 bytes long and ends with a line-feed (0x0A), so the byte after a line-feed is the first byte. In the short format the message is 16 bytes long and its first byte is the only one with the top bit set. The verdict is updated once per complete aligned message. A mismatch state bit records it, a sticky change flag records any change of that bit, and an interrupt output follows the change flag unless a mask input blocks it.

Top module: `trace_mon`

## Requirements
- R1: After reset the mismatch state, the change flag and the interrupt are all 0, and every expected-message location holds 0.
- R2: The mode field `modeSel` selects the long format with 2'b01 and the short format with 2'b10. With 2'b00 or 2'b11 no comparison takes place and received bytes leave the mismatch state unchanged.
- R3: In long mode, the byte that follows a received 0x0A is compared against location 0, and the following bytes against locations 1 to 63. The verdict is set in the cycle the 64th aligned byte is taken: 1 if any byte differed, 0 otherwise.
- R4: In short mode, a byte with bit 7 set is compared against location 0, and the next 15 bytes against locations 1 to 15. The verdict is set when the 16th byte is taken.
- R5: A complete aligned message that equals the stored message clears the mismatch state.
- R6: Bytes taken before any marker has been seen, and a partial message cut short by a new marker (long mode), do not change the mismatch state.
- R7: In either mode, when 2×(message length) consecutive taken bytes pass without a marker byte (0x0A in long mode, bit 7 set in short mode), the mismatch state is set on the last of them.
- R8: Every change of the mismatch state, 0 to 1 or 1 to 0, sets the change flag in the same cycle.
- R9: A one-cycle pulse on `deltaClr` clears the change flag. If the mismatch state changes in the same cycle, the flag stays set.
- R10: `irqOut` is 1 exactly when the change flag is 1 and `maskBit` is 0.
- R11: In the cycle that `modeSel` differs from its value in the previous cycle, alignment is dropped, any partial message is discarded and the byte in that cycle is ignored.
- R12: A write with `cfgWrEn` high stores `cfgWrData` at location `cfgAddr`. Later comparisons use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Marks the cycle in which traceByte carries this frame's byte |
| traceByte | input | 8 | Received path trace byte |
| modeSel | input | 2 | Message format select (01 long, 10 short, others off) |
| cfgWrEn | input | 1 | Write strobe for the expected-message file |
| cfgAddr | input | 6 | Expected-message location to write |
| cfgWrData | input | 8 | Expected byte to write |
| maskBit | input | 1 | 1 blocks the interrupt |
| deltaClr | input | 1 | Write-one-to-clear pulse for the change flag |
| mismatchState | output | 1 | 1 while the last verdict was a mismatch |
| deltaFlag | output | 1 | Sticky record of a mismatch state change |
| irqOut | output | 1 | Change flag gated by the mask |

## Verification
The checks over time assume that `deltaClr`, `modeSel` and `frameValid` are held at 0 or at a defined value during reset. This lets the first comparison against a past value after reset see reset-consistent inputs. They also assume that the mismatch state moves only on a cycle in which a byte is taken in an enabled mode whose value did not just change. The stimulus meets these assumptions: all inputs are driven from time zero, bytes are separated by idle cycles, and every mode switch happens while `frameValid` is low. Expected verdicts are worked out by counting the bytes since the last marker.

// File: rtl/trace_mon_pkg.sv
`timescale 1ns/1ps
package trace_mon_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_LONG  = 2'b01,
    MODE_SHORT = 2'b10,
    MODE_RSVD  = 2'b11
  } modeE;

  // strobes from the alignment control to the compare datapath
  typedef struct packed {
    logic accept;  // current byte belongs to an aligned message
    logic first;   // current byte is message location 0
    logic last;    // current byte is the final message location
    logic loss;    // marker missing for too long: force mismatch
  } dpStrobeT;

endpackage

// File: rtl/trace_mon_ctrl.sv
`timescale 1ns/1ps
module trace_mon_ctrl
  import trace_mon_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 64,
  parameter int unsigned SHORT_LEN = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] LF_MARK = 8'h0A,
  localparam int unsigned IDX_W  = $clog2(LONG_LEN),
  localparam int unsigned HUNT_W = $clog2(2*LONG_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [BYTE_W-1:0] traceByte,
  input  logic [1:0]        modeSel,
  output dpStrobeT          stb,
  output logic [IDX_W-1:0]  byteIdx
);

  localparam logic [IDX_W-1:0]  LONG_LAST  = IDX_W'(LONG_LEN - 1);
  localparam logic [IDX_W-1:0]  SHORT_LAST = IDX_W'(SHORT_LEN - 1);
  localparam logic [HUNT_W-1:0] LONG_HUNT  = HUNT_W'(2*LONG_LEN);
  localparam logic [HUNT_W-1:0] SHORT_HUNT = HUNT_W'(2*SHORT_LEN);

  logic [1:0]        prevMode;
  logic              aligned;
  logic [IDX_W-1:0]  nextIdx;
  logic [HUNT_W-1:0] huntCnt;

  logic              isLong;
  logic              isShort;
  logic              modeChg;
  logic              take;
  logic              markNow;
  logic              useByte;
  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [HUNT_W-1:0] huntLim;

  always_comb begin
    isLong  = (modeSel == MODE_LONG);
    isShort = (modeSel == MODE_SHORT);
    modeChg = (modeSel != prevMode);
    take    = frameValid && (isLong || isShort) && !modeChg;
    markNow = isLong ? (traceByte == LF_MARK) : traceByte[BYTE_W-1];
    lastIdx = isLong ? LONG_LAST : SHORT_LAST;
    huntLim = isLong ? LONG_HUNT : SHORT_HUNT;
    if (isShort && markNow) begin
      useByte = 1'b1;
      curIdx  = '0;
    end else begin
      useByte = aligned;
      curIdx  = nextIdx;
    end
    stb.accept = take && useByte;
    stb.first  = (curIdx == '0);
    stb.last   = (curIdx == lastIdx);
    stb.loss   = take && !markNow && (huntCnt == huntLim - 1'b1);
    byteIdx    = curIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMode <= MODE_OFF;
      aligned  <= 1'b0;
      nextIdx  <= '0;
      huntCnt  <= '0;
    end else begin
      prevMode <= modeSel;
      if (modeChg) begin
        aligned <= 1'b0;
        nextIdx <= '0;
        huntCnt <= '0;
      end else if (take) begin
        if (markNow) begin
          huntCnt <= '0;
        end else if (huntCnt != huntLim) begin
          huntCnt <= huntCnt + 1'b1;
        end
        if (isLong) begin
          // line-feed ends a message: the next byte is location 0
          if (markNow) begin
            aligned <= 1'b1;
            nextIdx <= '0;
          end else if (useByte && (curIdx != lastIdx)) begin
            nextIdx <= curIdx + 1'b1;
          end else begin
            aligned <= 1'b0;
          end
        end else begin
          // top-bit byte starts a message: it is location 0 itself
          if (useByte && (curIdx == lastIdx)) begin
            aligned <= 1'b0;
          end else if (useByte) begin
            aligned <= 1'b1;
            nextIdx <= curIdx + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/trace_mon_dp.sv
`timescale 1ns/1ps
module trace_mon_dp
  import trace_mon_pkg::*;
#(
  parameter int unsigned LONG_LEN = 64,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned IDX_W   = $clog2(LONG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [BYTE_W-1:0] traceByte,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic              deltaClr,
  output logic              mismatchState,
  output logic              deltaFlag
);

  logic [BYTE_W-1:0] expMem [LONG_LEN];
  logic              diffAcc;
  logic              stateQ;
  logic              deltaQ;
  logic              misNow;
  logic              stateNext;
  logic              stateChg;

  for (genvar g = 0; g < LONG_LEN; g++) begin : gExpEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        expMem[g] <= '0;
      end else if (cfgWrEn && (cfgAddr == IDX_W'(g))) begin
        expMem[g] <= cfgWrData;
      end
    end
  end

  always_comb begin
    misNow    = (stb.first ? 1'b0 : diffAcc) | (traceByte != expMem[byteIdx]);
    stateNext = stateQ;
    if (stb.loss) begin
      stateNext = 1'b1;
    end else if (stb.accept && stb.last) begin
      stateNext = misNow;
    end
    stateChg = (stateNext != stateQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      diffAcc <= 1'b0;
      stateQ  <= 1'b0;
      deltaQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      deltaQ <= stateChg | (deltaQ & ~deltaClr);
      if (stb.accept) begin
        diffAcc <= stb.last ? 1'b0 : misNow;
      end
    end
  end

  assign mismatchState = stateQ;
  assign deltaFlag     = deltaQ;

endmodule

// File: rtl/trace_mon.sv
`timescale 1ns/1ps
module trace_mon
  import trace_mon_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 64,
  parameter int unsigned SHORT_LEN = 16,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned IDX_W    = $clog2(LONG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [BYTE_W-1:0] traceByte,
  input  logic [1:0]        modeSel,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic              maskBit,
  input  logic              deltaClr,
  output logic              mismatchState,
  output logic              deltaFlag,
  output logic              irqOut
);

  dpStrobeT         stb;
  logic [IDX_W-1:0] byteIdx;

  trace_mon_ctrl #(
    .LONG_LEN (LONG_LEN),
    .SHORT_LEN(SHORT_LEN),
    .BYTE_W   (BYTE_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameValid(frameValid),
    .traceByte (traceByte),
    .modeSel   (modeSel),
    .stb       (stb),
    .byteIdx   (byteIdx)
  );

  trace_mon_dp #(
    .LONG_LEN(LONG_LEN),
    .BYTE_W  (BYTE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .byteIdx      (byteIdx),
    .traceByte    (traceByte),
    .cfgWrEn      (cfgWrEn),
    .cfgAddr      (cfgAddr),
    .cfgWrData    (cfgWrData),
    .deltaClr     (deltaClr),
    .mismatchState(mismatchState),
    .deltaFlag    (deltaFlag)
  );

  assign irqOut = deltaFlag & ~maskBit;

endmodule

// File: rtl/trace_mon_chk.sv
`timescale 1ns/1ps
module trace_mon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameValid,
  input logic [1:0] modeSel,
  input logic       deltaClr,
  input logic       mismatchState,
  input logic       deltaFlag
);

  AST_CHANGE_SETS_DELTA: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchState != $past(mismatchState)) |-> deltaFlag); // R8

  AST_CLEAR_WITHOUT_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(deltaClr) && $stable(mismatchState)) |-> !deltaFlag); // R9

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(deltaFlag) && !$past(deltaClr)) |-> deltaFlag); // R9

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> $stable(mismatchState)); // R6

  AST_OFF_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 || modeSel == 2'b11) |=> $stable(mismatchState)); // R2

  AST_MODE_SWITCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel)) |=> $stable(mismatchState)); // R11

endmodule

bind trace_mon trace_mon_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .frameValid   (frameValid),
  .modeSel      (modeSel),
  .deltaClr     (deltaClr),
  .mismatchState(mismatchState),
  .deltaFlag    (deltaFlag)
);

// File: tb/trace_mon_bench.sv
`timescale 1ns/1ps
module trace_mon_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic [7:0] traceByte = 8'h00;
  logic [1:0] modeSel = 2'b00;
  logic       cfgWrEn = 1'b0;
  logic [5:0] cfgAddr = 6'd0;
  logic [7:0] cfgWrData = 8'h00;
  logic       maskBit = 1'b0;
  logic       deltaClr = 1'b0;
  logic       mismatchState;
  logic       deltaFlag;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trace_mon u_trace_mon (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .traceByte(traceByte),
    .modeSel(modeSel), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .maskBit(maskBit), .deltaClr(deltaClr), .mismatchState(mismatchState),
    .deltaFlag(deltaFlag), .irqOut(irqOut)
  );

  function automatic logic [7:0] longExp(input int i);
    return (i == 63) ? 8'h0A : 8'(8'h20 + i);
  endfunction

  function automatic logic [7:0] shortExp(input int i);
    return (i == 0) ? 8'hC5 : 8'(8'h30 + i);
  endfunction

  task automatic expectOut(input string req, input logic s, input logic d, input logic q);
    checks++;
    if (mismatchState !== s || deltaFlag !== d || irqOut !== q) begin
      errors++;
      $display("FAIL %s: state/delta/irq actual %b%b%b expected %b%b%b",
               req, mismatchState, deltaFlag, irqOut, s, d, q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic clr);
    @(negedge clk);
    frameValid = 1'b1; traceByte = b; deltaClr = clr;
    @(negedge clk);
    frameValid = 1'b0; deltaClr = 1'b0;
  endtask

  task automatic sendRange(input int lo, input int hi, input bit shortMsg,
                           input int badIdx, input logic [7:0] badVal, input logic clrLast);
    for (int i = lo; i <= hi; i++) begin
      logic [7:0] b;
      b = shortMsg ? shortExp(i) : longExp(i);
      if (i == badIdx) b = badVal;
      sendByte(b, clrLast && (i == hi));
    end
  endtask

  task automatic writeExp(input int a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 6'(a); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    @(negedge clk);
  endtask

  task automatic pulseClr();
    @(negedge clk);
    deltaClr = 1'b1;
    @(negedge clk);
    deltaClr = 1'b0;
  endtask

  task automatic testReset();
    expectOut("R1 reset", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testOffMode();
    // R2: mode 00 takes no bytes; R1: memory zero so any compare would mismatch
    sendByte(8'h0A, 1'b0);
    for (int i = 0; i < 64; i++) sendByte(8'h33, 1'b0);
    expectOut("R2 off mode ignores bytes", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testLongMismatch();
    setMode(2'b01);
    for (int i = 0; i < 64; i++) writeExp(i, longExp(i));
    for (int i = 0; i < 10; i++) sendByte(8'h55, 1'b0);
    expectOut("R6 bytes before marker", 1'b0, 1'b0, 1'b0);
    sendByte(8'h0A, 1'b0);
    sendRange(0, 62, 1'b0, 5, 8'hFF, 1'b0);
    expectOut("R3 no verdict before 64th byte", 1'b0, 1'b0, 1'b0);
    sendRange(63, 63, 1'b0, -1, 8'h00, 1'b0);
    expectOut("R3 R8 R10 mismatch verdict", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testMaskAndClear();
    @(negedge clk); maskBit = 1'b1; #1;
    expectOut("R10 masked irq", 1'b1, 1'b1, 1'b0);
    @(negedge clk); maskBit = 1'b0; #1;
    expectOut("R10 unmasked irq", 1'b1, 1'b1, 1'b1);
    pulseClr();
    expectOut("R9 clear pulse", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testLongMatch();
    sendRange(0, 63, 1'b0, -1, 8'h00, 1'b0);
    expectOut("R5 R8 match clears state", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testPartialAndRace();
    sendRange(0, 19, 1'b0, 5, 8'hFF, 1'b0);
    sendByte(8'h0A, 1'b0);
    sendRange(0, 19, 1'b0, 5, 8'hFF, 1'b0);
    sendByte(8'h0A, 1'b0);
    expectOut("R6 partial messages discarded", 1'b0, 1'b1, 1'b1);
    sendRange(0, 63, 1'b0, 5, 8'hFF, 1'b1);
    expectOut("R9 change beats clear", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testCfgWrite();
    writeExp(5, 8'hFF);
    sendRange(0, 63, 1'b0, 5, 8'hFF, 1'b0);
    expectOut("R12 rewritten location used", 1'b0, 1'b1, 1'b1);
    writeExp(5, longExp(5));
  endtask

  task automatic testShortAndModeChange();
    sendRange(0, 63, 1'b0, 5, 8'hFF, 1'b0);
    expectOut("R3 mismatch again", 1'b1, 1'b1, 1'b1);
    sendRange(0, 29, 1'b0, -1, 8'h00, 1'b0);
    setMode(2'b10);
    for (int i = 0; i < 16; i++) writeExp(i, shortExp(i));
    for (int i = 0; i < 3; i++) sendByte(8'h11, 1'b0);
    expectOut("R11 R6 switch keeps state", 1'b1, 1'b1, 1'b1);
    sendRange(0, 15, 1'b1, -1, 8'h00, 1'b0);
    expectOut("R4 short match", 1'b0, 1'b1, 1'b1);
    sendRange(0, 15, 1'b1, 3, 8'h7F, 1'b0);
    expectOut("R4 short mismatch", 1'b1, 1'b1, 1'b1);
    sendRange(0, 7, 1'b1, -1, 8'h00, 1'b0);
    setMode(2'b11);
    setMode(2'b10);
    sendRange(8, 15, 1'b1, -1, 8'h00, 1'b0);
    expectOut("R11 mode change drops partial", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testLoss();
    sendRange(0, 15, 1'b1, -1, 8'h00, 1'b0);
    expectOut("R4 R5 short match", 1'b0, 1'b1, 1'b1);
    pulseClr();
    // 15 non-marker bytes already followed the marker; 32 trigger the loss
    for (int i = 0; i < 16; i++) sendByte(8'h11, 1'b0);
    expectOut("R7 one short of limit", 1'b0, 1'b0, 1'b0);
    sendByte(8'h11, 1'b0);
    expectOut("R7 marker loss", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testOffAgain();
    setMode(2'b00);
    sendRange(0, 15, 1'b1, -1, 8'h00, 1'b0);
    expectOut("R2 off mode holds state", 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOffMode();
    testLongMismatch();
    testMaskAndClear();
    testLongMatch();
    testPartialAndRace();
    testCfgWrite();
    testShortAndModeChange();
    testLoss();
    testOffAgain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule